// File: doc/BRIEF.md
# Segment-Select Approximate Multiplier

This block multiplies two unsigned P-bit operands through a narrower S-bit core multiplier. Each operand enters its own selection stage. When every bit above the low S bits is zero, the stage forwards the low S bits unchanged. Otherwise it forwards the top S bits and drops the low P−S bits. The core multiplies the two forwarded segments. A final stage then moves the core product back to its proper weight by a left shift. The shift is zero, P−S or 2·(P−S) positions, depending on how many operands were cut.

The block is purely combinational. The product and both segment flags follow the operands within the same cycle. Small operands give exact products. Large operands give a truncated estimate, and that estimate is never above the true product. The widths P and S are parameters. Elaboration stops unless P/2 ≤ S < P.

Top module: `ssm_approx_mult`

## Requirements
- R1: Each segment flag (`flag_a`, `flag_b`) is 1 exactly when its operand has a nonzero bit anywhere in positions P−1 down to S. Otherwise the flag is 0.
- R2: An operand whose flag is 0 enters the core as bits S−1..0, unchanged. When both flags are 0, `product` equals the exact product op_a·op_b.
- R3: An operand whose flag is 1 enters the core as bits P−1..P−S, and its low P−S bits are discarded.
- R4: The core product is zero-extended to 2P bits and shifted left by:
  - 0 when neither flag is set;
  - P−S when exactly one flag is set;
  - 2·(P−S) when both flags are set.
- R5: `product` never exceeds the exact product op_a·op_b.
- R6: The block holds no state. `product` and the flags reflect the operands present at the same moment, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | P | Unsigned multiplicand |
| op_b | input | P | Unsigned multiplier |
| flag_a | output | 1 | Set when op_a was truncated to its upper segment |
| flag_b | output | 1 | Set when op_b was truncated to its upper segment |
| product | output | 2P | Approximate unsigned product, 2P bits |

## Verification
Reaching the exact-one-flag shift from a hand-picked list is easy. The hard part is covering every boundary where an operand crosses 2^S, so that one flag flips while the other holds. Truncation errors of up to 2^(P−S)−1 per operand must also show up there.

The stimulus therefore sweeps every operand pair for P = 8. This drives each operand through every value on both sides of the 2^S threshold. Every result is compared bit for bit with an independent truncate-and-shift model. Exact equality is required wherever both operands are below 2^S.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    // Output re-weighting selector, decoded from the two segment flags.
    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SINGLE = 2'd1,
        SH_DOUBLE = 2'd2
    } shift_sel_e;

    typedef struct packed {
        logic a;
        logic b;
    } flag_pair_t;

    function automatic shift_sel_e shift_select(input flag_pair_t f);
        shift_sel_e s;
        case ({f.a, f.b})
            2'b00:   s = SH_NONE;
            2'b11:   s = SH_DOUBLE;
            default: s = SH_SINGLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ssm_segment_sel.sv
module ssm_segment_sel #(
    parameter int P = 8,
    parameter int S = 5
) (
    input  logic [P-1:0] operand,
    output logic         cut,
    output logic [S-1:0] segment
);
    localparam int DROP = P - S;

    always_comb begin
        cut     = |operand[P-1:S];
        segment = cut ? operand[P-1:DROP] : operand[S-1:0];
    end
endmodule

// File: rtl/ssm_core_mult.sv
module ssm_core_mult #(
    parameter int S = 5
) (
    input  logic [S-1:0]   seg_a,
    input  logic [S-1:0]   seg_b,
    output logic [2*S-1:0] core_prod
);
    always_comb begin
        core_prod = {{S{1'b0}}, seg_a} * {{S{1'b0}}, seg_b};
    end
endmodule

// File: rtl/ssm_shift_restore.sv
module ssm_shift_restore
    import ssm_pkg::*;
#(
    parameter int P = 8,
    parameter int S = 5
) (
    input  logic [2*S-1:0] core_prod,
    input  shift_sel_e     mode,
    output logic [2*P-1:0] product
);
    localparam int DROP = P - S;
    localparam int PAD  = 2 * P - 2 * S;

    logic [2*P-1:0] widened;

    always_comb begin
        widened = {{PAD{1'b0}}, core_prod};
        case (mode)
            SH_NONE:   product = widened;
            SH_SINGLE: product = widened << DROP;
            SH_DOUBLE: product = widened << (2 * DROP);
            default:   product = '0;
        endcase
    end
endmodule

// File: rtl/ssm_approx_mult.sv
module ssm_approx_mult
    import ssm_pkg::*;
#(
    parameter int P = 8,
    parameter int S = 5
) (
    input  logic [P-1:0]   op_a,
    input  logic [P-1:0]   op_b,
    output logic           flag_a,
    output logic           flag_b,
    output logic [2*P-1:0] product
);
    localparam int NOPS = 2;

    generate
        if (!((2 * S >= P) && (S < P))) begin : g_bad_width
            $fatal(1, "ssm_approx_mult: segment width must satisfy P/2 <= S < P");
        end
    endgenerate

    logic [P-1:0]   ops  [NOPS];
    logic [S-1:0]   segs [NOPS];
    logic [NOPS-1:0] cuts;
    logic [2*S-1:0] core_prod;
    flag_pair_t     flags;
    shift_sel_e     mode;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One selection stage per operand.
    for (genvar i = 0; i < NOPS; i++) begin : g_sel
        ssm_segment_sel #(.P(P), .S(S)) u_sel (
            .operand (ops[i]),
            .cut     (cuts[i]),
            .segment (segs[i])
        );
    end

    ssm_core_mult #(.S(S)) u_core (
        .seg_a     (segs[0]),
        .seg_b     (segs[1]),
        .core_prod (core_prod)
    );

    always_comb begin
        flags.a = cuts[0];
        flags.b = cuts[1];
        mode    = shift_select(flags);
    end

    ssm_shift_restore #(.P(P), .S(S)) u_shift (
        .core_prod (core_prod),
        .mode      (mode),
        .product   (product)
    );

    assign flag_a = flags.a;
    assign flag_b = flags.b;
endmodule

// File: rtl/ssm_approx_mult_chk.sv
module ssm_approx_mult_chk #(
    parameter int P = 8,
    parameter int S = 5
) (
    input logic [P-1:0]   op_a,
    input logic [P-1:0]   op_b,
    input logic           flag_a,
    input logic           flag_b,
    input logic [2*P-1:0] product
);
    localparam int DROP = P - S;
    localparam logic [P-1:0] LIMIT = P'(1) << S;

    logic [2*P-1:0] exact;
    logic [2*DROP-1:0] low2;
    logic [DROP-1:0] low1;

    always_comb begin
        exact = {{P{1'b0}}, op_a} * {{P{1'b0}}, op_b};
        low2  = product[2*DROP-1:0];
        low1  = product[DROP-1:0];
        AST_FLAG_A_RANGE: assert (flag_a == (op_a >= LIMIT)); // R1
        AST_FLAG_B_RANGE: assert (flag_b == (op_b >= LIMIT)); // R1
        AST_EXACT_SMALL: assert (flag_a || flag_b || product == exact); // R2
        AST_NO_OVERESTIMATE: assert (product <= exact); // R5
        AST_SINGLE_LOW_ZERO: assert ((flag_a == flag_b) || low1 == '0); // R4
        AST_DOUBLE_LOW_ZERO: assert (!(flag_a && flag_b) || low2 == '0); // R4
    end
endmodule

bind ssm_approx_mult ssm_approx_mult_chk #(.P(P), .S(S)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .flag_a  (flag_a),
    .flag_b  (flag_b),
    .product (product)
);

// File: tb/test_ssm_approx_mult.sv
module test_ssm_approx_mult;
    localparam int P = 8;
    localparam int S = 5;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 190000;

    typedef struct {
        int unsigned a;
        int unsigned b;
        int unsigned exp_prod;
        bit          exp_fa;
        bit          exp_fb;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [P-1:0]   op_a = '0;
    logic [P-1:0]   op_b = '0;
    logic           flag_a;
    logic           flag_b;
    logic [2*P-1:0] product;

    int errors = 0;
    int checks = 0;
    bit drive_done = 1'b0;
    item_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssm_approx_mult #(.P(P), .S(S)) i_ssm_approx_mult (
        .op_a    (op_a),
        .op_b    (op_b),
        .flag_a  (flag_a),
        .flag_b  (flag_b),
        .product (product)
    );

    // Reference model of the requirements, written independently.
    function automatic int unsigned ref_seg(input int unsigned v, output bit cut);
        cut = (v >> S) != 0;
        return cut ? (v >> (P - S)) : v;
    endfunction

    function automatic item_t make_item(input int unsigned a, input int unsigned b);
        item_t it;
        int unsigned sa, sb_v, sh;
        bit ca, cb;
        sa   = ref_seg(a, ca);
        sb_v = ref_seg(b, cb);
        sh   = (ca ? (P - S) : 0) + (cb ? (P - S) : 0);
        it.a = a;
        it.b = b;
        it.exp_prod = (sa * sb_v) << sh;
        it.exp_fa = ca;
        it.exp_fb = cb;
        return it;
    endfunction

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned exp, input item_t it);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, it.a, it.b, act, exp);
        end
    endtask

    task automatic drive(input int unsigned a, input int unsigned b);
        @(negedge clk);
        op_a = P'(a);
        op_b = P'(b);
        sb.push_back(make_item(a, b));
    endtask

    // Monitor: outputs are sampled half a period after the inputs change (R6).
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(flag_a == it.exp_fa, "R1 flag_a", flag_a, it.exp_fa, it);
            check(flag_b == it.exp_fb, "R1 flag_b", flag_b, it.exp_fb, it);
            if (!it.exp_fa && !it.exp_fb) begin
                check(product == it.a * it.b, "R2 R6 exact", product, it.a * it.b, it);
            end else begin
                check(product == it.exp_prod, "R3 R4 R6 truncate-shift", product, it.exp_prod, it);
            end
            check(product <= it.a * it.b, "R5 no overestimate", product, it.a * it.b, it);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Reset state: zero operands give a zero product with both flags clear (R2).
        @(negedge clk);
        checks++;
        if (product !== '0 || flag_a !== 1'b0 || flag_b !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset-state actual=%0d expected=0", product);
        end
        rst = 1'b0;
        // Directed corners: 255*255 -> 31*31<<6; 39*1 truncated to 32 (R3); 31*31 exact.
        drive(255, 255);
        drive(31, 31);
        drive(39, 1);
        drive(32, 31);
        drive(31, 32);
        // Full sweep of all operand pairs.
        for (int a = 0; a < (1 << P); a++) begin
            for (int b = 0; b < (1 << P); b++) begin
                drive(a, b);
            end
        end
        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        drive_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (drive_done);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule